// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a simple synchronous bus and an on-chip word-wide storage array and makes that array behave like a command-driven parallel flash. Bus writes are not stored directly. Instead, the low byte of each write is treated as a command. A one-bit write-cycle counter and a latched command decide what each write means. The latched command also selects what a bus read returns: the array word, the status byte, the identifier bytes or the query bytes.

Word programming takes two writes: the command first, then the data. Sector erase also takes two writes: the command first, then a confirm. Erase is carried out by a walker that writes all-ones to every word of the addressed sector, one word per cycle. While the walker runs, the status ready bit is low and bus writes are ignored. When the write-to-buffer command is given, the block only hands off to a separate data path: it pulses a start strobe with the address. A static read-only input turns program and erase into error reports. The status byte holds three flags:
- bit 7: ready
- bit 5: erase error
- bit 4: program error

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, and the status byte is 0x80.
- R2: In array-read mode a read returns the stored word at the read address one cycle later. The command bytes 0xFF, 0xF0 and 0x00 all select array-read mode from the first cycle.
- R3: When the latched command is anything other than array read (0x00), identifier (0x90) or query (0x98), a read returns the status byte copied into every 8-bit lane of the data word.
- R4: A first-cycle write of 0x10 or 0x40, followed by a second write, stores the whole second-write data at the second-write address. It then sets status bit 7 and returns the cycle counter to the first cycle.
- R5: A first-cycle write of 0x20 followed by 0xD0 erases the sector that contains the confirm address to 0xFFFF in every word. A sector is SECT_WORDS aligned words, chosen by the upper address bits. Status bit 7 reads 0 until the erase completes and then reads 1. Bus writes made during the erase have no effect.
- R6: After 0x20, a second write of 0xFF, or of any value other than 0xD0, returns the block to array-read mode and does not erase anything.
- R7: When ro_i is high, a program does not touch storage and sets status bits 4 and 7. When ro_i is high, an erase confirm does not touch storage and sets status bits 5 and 7.
- R8: The command 0x50 clears the whole status byte to 0x00 and selects array-read mode.
- R9: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and keeps status mode. After 0x60, any other second write returns the block to array-read mode.
- R10: After 0x90, a read at address 0 returns MFR_ID and a read at address 1 returns DEV_ID. A read at any other address returns 0x00. The byte is copied into every lane.
- R11: After 0x98, a read at index 0x10, 0x11, 0x12 or 0x13 returns 0x51, 0x52, 0x59 or 0x01 respectively. Every other index returns 0x00. The byte is copied into every lane.
- R12: Any first-cycle command byte that is not one of the defined commands returns the block to array-read mode.
- R13: The command 0xE8 sets status bit 7 and selects status mode. In the cycle after the write, it raises wbuf_start_o for exactly one cycle, with wbuf_addr_o holding the write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ro_i | input | 1 | Read-only configuration, static during operation |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Bus word address |
| bus_wdata_i | input | 8*LANES | Bus write data (low byte is the command) |
| bus_rdata_o | output | 8*LANES | Read data, valid the cycle after bus_re_i |
| mem_we_o | output | 1 | Storage write enable |
| mem_addr_o | output | ADDR_W | Storage word address |
| mem_wdata_o | output | 8*LANES | Storage write data |
| mem_rdata_i | input | 8*LANES | Storage read data, combinational from mem_addr_o |
| wbuf_start_o | output | 1 | Buffered-write hand-off strobe |
| wbuf_addr_o | output | ADDR_W | Address captured with the hand-off strobe |

## Verification
The assertions depend on three assumptions about the inputs:
- ro_i stays constant while a command sequence or an erase is in progress.
- bus_we_i and bus_re_i are never high in the same cycle.
- The storage answers combinationally from mem_addr_o.

The bench meets these assumptions as follows. It changes ro_i only when the block is idle in array-read mode. It spaces every strobe two cycles apart. It models the storage as a combinational-read array that is written on the clock edge. During an erase it issues one extra write. The ready bit must not return, and the mode must not change, until the walker has swept all the sector's words.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  parameter int unsigned LANE_W = 8;

  parameter logic [7:0] CMD_ARRAY    = 8'h00;
  parameter logic [7:0] CMD_PROG_A   = 8'h10;
  parameter logic [7:0] CMD_ERASE    = 8'h20;
  parameter logic [7:0] CMD_PROG_B   = 8'h40;
  parameter logic [7:0] CMD_CLR      = 8'h50;
  parameter logic [7:0] CMD_LOCK     = 8'h60;
  parameter logic [7:0] CMD_STAT     = 8'h70;
  parameter logic [7:0] CMD_IDENT    = 8'h90;
  parameter logic [7:0] CMD_QUERY    = 8'h98;
  parameter logic [7:0] CMD_WBUF     = 8'hE8;
  parameter logic [7:0] CMD_CONFIRM  = 8'hD0;
  parameter logic [7:0] CMD_LOCK_ALT = 8'h01;

  parameter int unsigned ST_READY     = 7;
  parameter int unsigned ST_ERASE_ERR = 5;
  parameter int unsigned ST_PROG_ERR  = 4;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY} rd_mode_e;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ro_i,
  input  logic              we_i,
  input  logic [7:0]        cmd_byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              done_i,
  output rd_mode_e          mode_o,
  output logic [7:0]        status_o,
  output logic              prog_we_o,
  output logic              erase_start_o,
  output logic              wbuf_start_o,
  output logic [ADDR_W-1:0] wbuf_addr_o
);
  logic [7:0] cmd_q, cmd_d, status_q, status_d;
  logic       wcycle_q, wcycle_d, wbuf_d;

  always_comb begin
    cmd_d         = cmd_q;
    wcycle_d      = wcycle_q;
    status_d      = status_q;
    prog_we_o     = 1'b0;
    erase_start_o = 1'b0;
    wbuf_d        = 1'b0;
    if (we_i && !busy_i) begin
      if (!wcycle_q) begin
        case (cmd_byte_i)
          CMD_PROG_A, CMD_PROG_B, CMD_ERASE, CMD_LOCK: begin
            cmd_d    = cmd_byte_i;
            wcycle_d = 1'b1;
          end
          CMD_CLR: begin
            status_d = '0;
            cmd_d    = CMD_ARRAY;
          end
          CMD_STAT, CMD_IDENT, CMD_QUERY: cmd_d = cmd_byte_i;
          CMD_WBUF: begin
            cmd_d              = CMD_WBUF;
            status_d[ST_READY] = 1'b1;
            wbuf_d             = 1'b1;
          end
          default: cmd_d = CMD_ARRAY;  // read-array aliases and unknown codes
        endcase
      end else begin
        wcycle_d = 1'b0;
        case (cmd_q)
          CMD_PROG_A, CMD_PROG_B: begin
            if (ro_i) status_d[ST_PROG_ERR] = 1'b1;
            else      prog_we_o = 1'b1;
            status_d[ST_READY] = 1'b1;
          end
          CMD_ERASE: begin
            if (cmd_byte_i == CMD_CONFIRM) begin
              if (ro_i) begin
                status_d[ST_ERASE_ERR] = 1'b1;
                status_d[ST_READY]     = 1'b1;
              end else begin
                erase_start_o      = 1'b1;
                status_d[ST_READY] = 1'b0;
              end
            end else begin
              cmd_d = CMD_ARRAY;
            end
          end
          CMD_LOCK: begin
            if (cmd_byte_i == CMD_CONFIRM || cmd_byte_i == CMD_LOCK_ALT)
              status_d[ST_READY] = 1'b1;
            else
              cmd_d = CMD_ARRAY;
          end
          default: cmd_d = CMD_ARRAY;
        endcase
      end
    end
    if (done_i) status_d[ST_READY] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q        <= CMD_ARRAY;
      wcycle_q     <= 1'b0;
      status_q     <= 8'h80;
      wbuf_start_o <= 1'b0;
      wbuf_addr_o  <= '0;
    end else begin
      cmd_q        <= cmd_d;
      wcycle_q     <= wcycle_d;
      status_q     <= status_d;
      wbuf_start_o <= wbuf_d;
      if (wbuf_d) wbuf_addr_o <= addr_i;
    end
  end

  always_comb begin
    case (cmd_q)
      CMD_ARRAY: mode_o = RD_ARRAY;
      CMD_IDENT: mode_o = RD_IDENT;
      CMD_QUERY: mode_o = RD_QUERY;
      default:   mode_o = RD_STATUS;
    endcase
  end

  assign status_o = status_q;

  assert_busy_ignores_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> ($stable(cmd_q) && $stable(wcycle_q)));
  assert_second_cycle_owner_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcycle_q |-> (cmd_q == CMD_PROG_A || cmd_q == CMD_PROG_B ||
                  cmd_q == CMD_ERASE  || cmd_q == CMD_LOCK));
  assert_clear_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_i && !wcycle_q && cmd_byte_i == CMD_CLR)
      |=> (status_q == 8'h00 && cmd_q == CMD_ARRAY));
  assert_wbuf_ready_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbuf_start_o |-> (cmd_q == CMD_WBUF && status_q[ST_READY]));
  assert_erase_writable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> !ro_i);
endmodule

// File: rtl/flash_erase_walk.sv
module flash_erase_walk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SECT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-SECT_W-1:0] sect_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     we_o,
  output logic [ADDR_W-1:0]        addr_o
);
  logic [SECT_W-1:0]        idx_q;
  logic [ADDR_W-SECT_W-1:0] sect_q;
  logic                     last;

  assign last   = (idx_q == {SECT_W{1'b1}});
  assign done_o = busy_o && last;
  assign we_o   = busy_o;
  assign addr_o = {sect_q, idx_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_q  <= '0;
      sect_q <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      idx_q  <= '0;
      sect_q <= sect_i;
    end else if (busy_o) begin
      idx_q <= idx_q + 1'b1;
      if (last) busy_o <= 1'b0;
    end
  end

  assert_walk_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && addr_o[SECT_W-1:0] == '0));
  assert_walk_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/flash_read_sel.sv
module flash_read_sel
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter logic [7:0]  MFR_ID = 8'h89,
  parameter logic [7:0]  DEV_ID = 8'h18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    re_i,
  input  rd_mode_e                mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              status_i,
  input  logic [LANES*LANE_W-1:0] array_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [LANE_W-1:0] info_byte;
  logic [DATA_W-1:0] info_word, rd_d;

  function automatic logic [7:0] query_byte(input logic [ADDR_W-1:0] idx);
    case (idx)
      ADDR_W'(8'h10): query_byte = 8'h51;
      ADDR_W'(8'h11): query_byte = 8'h52;
      ADDR_W'(8'h12): query_byte = 8'h59;
      ADDR_W'(8'h13): query_byte = 8'h01;
      default:        query_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    case (mode_i)
      RD_IDENT: info_byte = (addr_i == ADDR_W'(0)) ? MFR_ID :
                            (addr_i == ADDR_W'(1)) ? DEV_ID : 8'h00;
      RD_QUERY: info_byte = query_byte(addr_i);
      default:  info_byte = status_i;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign info_word[l*LANE_W +: LANE_W] = info_byte;
    if (l > 0) begin : g_chk
      assert_lane_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && mode_i != RD_ARRAY) |=> (rdata_o[l*LANE_W +: LANE_W] == rdata_o[LANE_W-1:0]));
    end
  end

  assign rd_d = (mode_i == RD_ARRAY) ? array_i : info_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LANES      = 2,
  parameter int unsigned SECT_WORDS = 16,
  parameter logic [7:0]  MFR_ID     = 8'h89,
  parameter logic [7:0]  DEV_ID     = 8'h18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ro_i,
  input  logic                    bus_we_i,
  input  logic                    bus_re_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [LANES*LANE_W-1:0] bus_wdata_i,
  output logic [LANES*LANE_W-1:0] bus_rdata_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LANES*LANE_W-1:0] mem_wdata_o,
  input  logic [LANES*LANE_W-1:0] mem_rdata_i,
  output logic                    wbuf_start_o,
  output logic [ADDR_W-1:0]       wbuf_addr_o
);
  localparam int unsigned SECT_W = $clog2(SECT_WORDS);

  rd_mode_e          mode;
  logic [7:0]        status;
  logic              prog_we, erase_start, busy, done, walk_we;
  logic [ADDR_W-1:0] walk_addr;

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .ro_i,
    .we_i          (bus_we_i),
    .cmd_byte_i    (bus_wdata_i[7:0]),
    .addr_i        (bus_addr_i),
    .busy_i        (busy),
    .done_i        (done),
    .mode_o        (mode),
    .status_o      (status),
    .prog_we_o     (prog_we),
    .erase_start_o (erase_start),
    .wbuf_start_o,
    .wbuf_addr_o
  );

  flash_erase_walk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i (erase_start),
    .sect_i  (bus_addr_i[ADDR_W-1:SECT_W]),
    .busy_o  (busy),
    .done_o  (done),
    .we_o    (walk_we),
    .addr_o  (walk_addr)
  );

  flash_read_sel #(.ADDR_W(ADDR_W), .LANES(LANES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk_i, .rst_ni,
    .re_i     (bus_re_i),
    .mode_i   (mode),
    .addr_i   (bus_addr_i),
    .status_i (status),
    .array_i  (mem_rdata_i),
    .rdata_o  (bus_rdata_o)
  );

  assign mem_we_o    = walk_we | prog_we;
  assign mem_addr_o  = busy ? walk_addr : bus_addr_i;
  assign mem_wdata_o = busy ? '1 : bus_wdata_i;

  assert_ro_no_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !ro_i);
  assert_no_prog_in_erase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !prog_we);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, ro = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, wbuf_addr;
  logic mem_we, wbuf_start;
  logic [DW-1:0] mem [256];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ro_i(ro), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .wbuf_start_o(wbuf_start), .wbuf_addr_o(wbuf_addr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i[7:0]);
    end else if (mem_we) mem[mem_addr] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr];

  function automatic logic [15:0] init_val(input logic [7:0] a);
    return {a ^ 8'hC3, a};
  endfunction
  function automatic logic [15:0] prog_val(input logic [7:0] a);
    return {a, ~a};
  endfunction
  function automatic logic [15:0] rep(input logic [7:0] b);
    return {b, b};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'd7, v);           check("R1 array after reset", v, init_val(8'd7));
    wr(8'd0, 16'h0070); rd(8'd0, v); check("R1 reset status", v, 16'h8080);

    // R4 program every word, alternating the two program codes
    for (int a = 0; a < 256; a++) begin
      wr(a[7:0], a[0] ? 16'h0010 : 16'h0040);
      wr(a[7:0], prog_val(a[7:0]));
    end
    rd(8'd3, v); check("R3 status after program", v, 16'h8080);
    wr(8'd0, 16'h00FF);
    for (int a = 0; a < 256; a++) begin
      rd(a[7:0], v); check("R4 program readback", v, prog_val(a[7:0]));
    end

    wr(8'd0, 16'h0070); wr(8'd0, 16'h00F0);
    rd(8'd10, v); check("R2 exit via F0", v, prog_val(8'd10));
    wr(8'd0, 16'h0070); wr(8'd0, 16'h0000);
    rd(8'd11, v); check("R2 exit via 00", v, prog_val(8'd11));

    // R5 erase sector 3
    wr(8'h35, 16'h0020); wr(8'h3A, 16'h00D0);
    rd(8'd0, v); check("R5 busy status", v, 16'h0000);
    wr(8'd0, 16'h00FF);
    repeat (20) @(negedge clk);
    rd(8'd0, v); check("R5 ready and write ignored", v, 16'h8080);
    wr(8'd0, 16'h00FF);
    for (int a = 0; a < 256; a++) begin
      rd(a[7:0], v);
      check("R5 erase sweep", v, (a / 16 == 3) ? 16'hFFFF : prog_val(a[7:0]));
    end

    wr(8'h50, 16'h0020); wr(8'h50, 16'h0055);
    rd(8'h50, v); check("R6 bad confirm", v, prog_val(8'h50));
    wr(8'h60, 16'h0020); wr(8'h60, 16'h00FF);
    rd(8'h60, v); check("R6 abort", v, prog_val(8'h60));

    // R7 read-only
    ro = 1'b1;
    wr(8'd0, 16'h0050);
    wr(8'd5, 16'h0040); wr(8'd5, 16'h1234);
    rd(8'd5, v); check("R7 program error", v, 16'h9090);
    wr(8'd0, 16'h00FF); rd(8'd5, v); check("R7 no store", v, prog_val(8'd5));
    wr(8'd0, 16'h0050);
    wr(8'h40, 16'h0020); wr(8'h40, 16'h00D0);
    rd(8'h40, v); check("R7 erase error", v, 16'hA0A0);
    wr(8'd0, 16'h00FF); rd(8'h41, v); check("R7 no erase", v, prog_val(8'h41));
    ro = 1'b0;

    wr(8'd0, 16'h0050);
    rd(8'd12, v); check("R8 clear to array", v, prog_val(8'd12));
    wr(8'd0, 16'h0070); rd(8'd0, v); check("R8 status zero", v, 16'h0000);

    wr(8'd0, 16'h0060); wr(8'd0, 16'h00D0);
    rd(8'd0, v); check("R9 lock D0", v, 16'h8080);
    wr(8'd0, 16'h0050);
    wr(8'd0, 16'h0060); wr(8'd0, 16'h0001);
    rd(8'd0, v); check("R9 lock 01", v, 16'h8080);
    wr(8'd0, 16'h0060); wr(8'd0, 16'h0033);
    rd(8'd9, v); check("R9 bad lock", v, prog_val(8'd9));

    wr(8'd0, 16'h0070); wr(8'd0, 16'h0077);
    rd(8'd13, v); check("R12 unknown cmd", v, prog_val(8'd13));

    wr(8'd0, 16'h0090);
    for (int a = 0; a < 256; a++) begin
      rd(a[7:0], v);
      check("R10 ident", v, rep(a == 0 ? 8'h89 : a == 1 ? 8'h18 : 8'h00));
    end
    wr(8'd0, 16'h0098);
    for (int a = 0; a < 256; a++) begin
      rd(a[7:0], v);
      check("R11 query", v, rep(a == 16 ? 8'h51 : a == 17 ? 8'h52 :
                                a == 18 ? 8'h59 : a == 19 ? 8'h01 : 8'h00));
    end

    wr(8'd0, 16'h0050);
    wr(8'h37, 16'h00E8);
    check("R13 strobe high", {15'd0, wbuf_start}, 16'd1);
    check("R13 strobe addr", {8'd0, wbuf_addr}, 16'h0037);
    @(negedge clk);
    check("R13 strobe one cycle", {15'd0, wbuf_start}, 16'd0);
    rd(8'd0, v); check("R13 status ready", v, 16'h8080);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule